// File: doc/BRIEF.md
# Multiprocessor Asynchronous Serial Receiver

This block takes one asynchronous NRZ input line and turns each received frame into a parallel word. A 16-bit divisor, supplied as two 8-bit halves, sets the rate of an internal sampling tick. That tick runs at sixteen times the bit rate. Each bit is sampled once, at its middle. The frame shape is set by configuration inputs: one start bit, a data length of 1 to 8 bits, an optional address-marker bit, an optional even or odd parity bit, and one or two stop bits.

A completed word moves into a holding register. The shifter is then free, so the next frame can arrive while software still holds the previous word. The holding register reports ready and carries parity, framing, overrun and break flags, plus a summary error and an interrupt output. Two wake-up schemes let a node on a shared line sleep through traffic meant for other nodes until an address word arrives. In one scheme an extra marker bit after the data flags the address. In the other, a long idle gap on the line flags it.

Top module: `mpuart_rx`

## Requirements
- R1: A frame begins with one low start bit. It is followed by `word_len`+1 data bits, least significant bit first (`word_len`=0 means 1 bit, 7 means 8 bits). The word appears right-justified on `rx_data`, with the unused upper bits at zero.
- R2: With divisor D = {`baud_hi`,`baud_lo`}, a sampling tick occurs every D+1 clocks and one bit lasts 16 ticks. A low pulse shorter than half a bit is rejected as a false start and produces no word.
- R3: When `parity_en` is 1, a parity bit follows the data (and the address marker, if present) and covers both. `parity_odd`=0 selects even parity and 1 selects odd. A mismatch sets `parity_err` together with the stored word.
- R4: `two_stop` selects one or two stop bits. A low level where a stop bit is expected sets `frame_err`. After that, no new start is recognised until the line has returned high.
- R5: `rx_ready` rises when a word is stored and falls after a one-cycle `rd` pulse. The stored word stays unchanged while the next frame is being shifted in.
- R6: If a word is stored while `rx_ready` is still 1 and no `rd` occurs in that cycle, `overrun_err` is set and the new word replaces the old one. `rd` clears `overrun_err`.
- R7: If the line stays low for a whole configured frame time (16 ticks per bit, counting every bit of the frame), `break_det` is set. It stays set until `rd`.
- R8: `rx_error` is 1 exactly when any of `parity_err`, `frame_err`, `overrun_err` or `break_det` is 1. `rd` clears all four.
- R9: `rx_irq` is asserted for ready or error conditions only when `rx_irq_en` is 1. A detected break asserts `rx_irq` regardless of `rx_irq_en`.
- R10: With `mp_mode`=2 (address marker), one extra bit follows the data. Its value is reported on `rx_addr` with the word.
- R11: With `mp_mode`=1 (idle gap), a frame whose start bit follows at least 10 bit times of high line is an address word (`rx_addr`=1). Frames following shorter gaps give `rx_addr`=0.
- R12: With `mp_mode` 1 or 2 and `sleep`=1, non-address words are discarded and change no flag and no output. Address words are stored normally. With `mp_mode`=0 (or 3), `sleep` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial input line, idles high |
| baud_hi | input | 8 | Upper half of the rate divisor |
| baud_lo | input | 8 | Lower half of the rate divisor |
| word_len | input | 3 | Data bits minus one |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | Two stop bits expected |
| mp_mode | input | 2 | 0 none, 1 idle gap, 2 address marker |
| sleep | input | 1 | Discard non-address words |
| rx_irq_en | input | 1 | Enable for ready and error interrupt |
| rd | input | 1 | One-cycle read strobe, clears ready and flags |
| rx_data | output | 8 | Stored word, right-justified |
| rx_addr | output | 1 | Stored word is an address |
| rx_ready | output | 1 | Unread word is held |
| parity_err | output | 1 | Parity mismatch on stored word |
| frame_err | output | 1 | Missing stop bit on stored word |
| overrun_err | output | 1 | Unread word was replaced |
| break_det | output | 1 | Line held low for a frame time |
| rx_error | output | 1 | Any error flag set |
| rx_irq | output | 1 | Interrupt request |

## Verification
A bit counter or sample phase that is off by one shows up within the next frame. The data bits come out shifted, or the parity or stop sample lands on the wrong bit, so a wrong word or a spurious parity or framing flag appears as soon as the stop bit has passed. An incorrect wake-up state is just as visible after one frame. Either a word that sleep should have discarded raises `rx_ready`, or an address word is lost or reported with the wrong `rx_addr`. A low-run or idle-gap counter that is wrong appears as `break_det` rising too early or too late relative to the frame time, or as the first word after a long gap not being marked as an address.

// File: rtl/mpuart_rx_pkg.sv
package mpuart_rx_pkg;
   typedef enum logic [1:0] {
      MP_NONE = 2'd0,
      MP_IDLE = 2'd1,
      MP_ADDR = 2'd2
   } mp_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_DATA, ST_ADDR, ST_PAR, ST_STOP, ST_WAIT
   } rx_state_e;

   typedef struct packed {
      logic is_addr;
      logic pe;
      logic fe;
   } rx_tag_t;
endpackage

// File: rtl/mpuart_rx_sync.sv
module mpuart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] pipe;

   if (STAGES < 2) begin : g_bad_stages
      $error("mpuart_rx_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[0] <= 1'b1;
            else        pipe[0] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[i] <= 1'b1;
            else        pipe[i] <= pipe[i-1];
      end
   end

   assign dout = pipe[STAGES-1];
endmodule

// File: rtl/mpuart_rx_baud.sv
module mpuart_rx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        cnt <= '0;
      else if (cnt == 0) cnt <= div;
      else               cnt <= cnt - 1'b1;

   assign tick = (cnt == 0);

   // R2: a nonzero divisor never yields back-to-back ticks
   p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != 0) |=> !tick);
endmodule

// File: rtl/mpuart_rx_frame.sv
module mpuart_rx_frame
   import mpuart_rx_pkg::*;
#(
   parameter int MAX_BITS  = 8,
   parameter int OVS       = 16,
   parameter int IDLE_BITS = 10,
   localparam int LEN_W    = $clog2(MAX_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                rxd,
   input  logic [LEN_W-1:0]    word_len,
   input  logic                parity_en,
   input  logic                parity_odd,
   input  logic                two_stop,
   input  logic [1:0]          mp_mode,
   output logic                done,
   output logic [MAX_BITS-1:0] data,
   output rx_tag_t             tag,
   output logic                brk_pulse
);
   localparam int CNT_W      = $clog2(OVS);
   localparam int MID        = OVS / 2 - 1;
   localparam int RUN_W      = $clog2(OVS * (MAX_BITS + 6));
   localparam int IDLE_TICKS = IDLE_BITS * OVS;
   localparam int IDLE_W     = $clog2(IDLE_TICKS + 1);

   rx_state_e            state;
   logic [CNT_W-1:0]     os_cnt;
   logic [LEN_W-1:0]     bit_cnt;
   logic [MAX_BITS-1:0]  shreg;
   logic                 addr_bit, idle_flag, par_acc, pe_r, fe_r, stop_idx;
   logic [RUN_W-1:0]     run_cnt, frame_ticks;
   logic [IDLE_W-1:0]    idle_cnt;
   logic                 samp, use_addr;
   logic [LEN_W-1:0]     shamt;

   assign use_addr    = (mp_mode == MP_ADDR);
   assign samp        = tick && (os_cnt == CNT_W'(OVS - 1));
   assign frame_ticks = (RUN_W'(word_len) + RUN_W'(3) + RUN_W'(use_addr)
                         + RUN_W'(parity_en) + RUN_W'(two_stop)) * RUN_W'(OVS);
   assign shamt       = LEN_W'(MAX_BITS - 1) - word_len;
   assign data        = shreg >> shamt;

   always_comb begin
      tag.pe = pe_r;
      tag.fe = fe_r;
      case (mp_mode)
         MP_ADDR: tag.is_addr = addr_bit;
         MP_IDLE: tag.is_addr = idle_flag;
         default: tag.is_addr = 1'b0;
      endcase
   end

   // low-run (break) and high-run (idle gap) counters, in ticks
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         run_cnt   <= '0;
         idle_cnt  <= '0;
         brk_pulse <= 1'b0;
      end else begin
         brk_pulse <= 1'b0;
         if (tick) begin
            if (!rxd) begin
               idle_cnt <= '0;
               if (run_cnt != '1) run_cnt <= run_cnt + 1'b1;
               if (run_cnt == frame_ticks - 1'b1) brk_pulse <= 1'b1;
            end else begin
               run_cnt <= '0;
               if (idle_cnt != IDLE_W'(IDLE_TICKS)) idle_cnt <= idle_cnt + 1'b1;
            end
         end
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state     <= ST_IDLE;
         os_cnt    <= '0;
         bit_cnt   <= '0;
         shreg     <= '0;
         addr_bit  <= 1'b0;
         idle_flag <= 1'b0;
         par_acc   <= 1'b0;
         pe_r      <= 1'b0;
         fe_r      <= 1'b0;
         stop_idx  <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (state != ST_IDLE && state != ST_WAIT && tick)
            os_cnt <= samp ? '0 : os_cnt + 1'b1;
         case (state)
            ST_IDLE:
               if (tick && !rxd) begin
                  state     <= ST_START;
                  os_cnt    <= '0;
                  idle_flag <= (idle_cnt == IDLE_W'(IDLE_TICKS));
               end
            ST_START:
               if (tick && os_cnt == CNT_W'(MID)) begin
                  os_cnt <= '0;
                  if (rxd) state <= ST_IDLE;
                  else begin
                     state    <= ST_DATA;
                     bit_cnt  <= '0;
                     shreg    <= '0;
                     addr_bit <= 1'b0;
                     par_acc  <= 1'b0;
                     pe_r     <= 1'b0;
                     fe_r     <= 1'b0;
                     stop_idx <= 1'b0;
                  end
               end
            ST_DATA:
               if (samp) begin
                  shreg   <= {rxd, shreg[MAX_BITS-1:1]};
                  par_acc <= par_acc ^ rxd;
                  bit_cnt <= bit_cnt + 1'b1;
                  if (bit_cnt == word_len)
                     state <= use_addr ? ST_ADDR : (parity_en ? ST_PAR : ST_STOP);
               end
            ST_ADDR:
               if (samp) begin
                  addr_bit <= rxd;
                  par_acc  <= par_acc ^ rxd;
                  state    <= parity_en ? ST_PAR : ST_STOP;
               end
            ST_PAR:
               if (samp) begin
                  pe_r  <= par_acc ^ rxd ^ parity_odd;
                  state <= ST_STOP;
               end
            ST_STOP:
               if (samp) begin
                  if (!rxd) begin
                     fe_r  <= 1'b1;
                     done  <= 1'b1;
                     state <= ST_WAIT;
                  end else if (two_stop && !stop_idx) begin
                     stop_idx <= 1'b1;
                  end else begin
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end
               end
            ST_WAIT:
               if (rxd) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end

   // R2: frame progress only advances on a sampling tick
   p_state_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state != $past(state) && $past(state) != ST_WAIT) |-> $past(tick));
   // R4: a word reported with a framing error leaves the receiver waiting for high
   p_fe_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && tag.fe) |-> state == ST_WAIT);
   // R1: a word is delivered as a single-cycle pulse
   p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/mpuart_rx_hold.sv
module mpuart_rx_hold
   import mpuart_rx_pkg::*;
#(
   parameter int MAX_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done,
   input  logic [MAX_BITS-1:0] data_in,
   input  rx_tag_t             tag,
   input  logic                brk_pulse,
   input  logic [1:0]          mp_mode,
   input  logic                sleep,
   input  logic                rd,
   output logic [MAX_BITS-1:0] data,
   output logic                is_addr,
   output logic                ready,
   output logic                pe,
   output logic                fe,
   output logic                oe,
   output logic                brk
);
   logic wake_on, accept;

   assign wake_on = (mp_mode == MP_IDLE) || (mp_mode == MP_ADDR);
   assign accept  = done && (!wake_on || !sleep || tag.is_addr);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         data    <= '0;
         is_addr <= 1'b0;
         ready   <= 1'b0;
         pe      <= 1'b0;
         fe      <= 1'b0;
         oe      <= 1'b0;
         brk     <= 1'b0;
      end else begin
         if (rd) begin
            ready <= 1'b0;
            pe    <= 1'b0;
            fe    <= 1'b0;
            oe    <= 1'b0;
            brk   <= 1'b0;
         end
         if (brk_pulse) brk <= 1'b1;
         if (accept) begin
            data    <= data_in;
            is_addr <= tag.is_addr;
            pe      <= tag.pe;
            fe      <= tag.fe;
            ready   <= 1'b1;
            if (ready && !rd) oe <= 1'b1;
         end
      end

   // R5: ready only rises when a word has just completed
   p_ready_from_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(done));
   // R5: a read with no new word empties the holding register
   p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !done) |=> !ready);
   // R6: an overrun always coexists with an unread word
   p_overrun_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> ready);
   // R12: a discarded word leaves the holding register untouched
   p_sleep_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (done && wake_on && sleep && !tag.is_addr && !rd && !brk_pulse)
      |=> ($stable(ready) && $stable(data) && $stable(pe) && $stable(fe) && $stable(oe)));
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
   import mpuart_rx_pkg::*;
#(
   parameter int MAX_BITS    = 8,
   parameter int OVS         = 16,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_BITS   = 10,
   localparam int LEN_W      = $clog2(MAX_BITS),
   localparam int HALF_W     = DIV_W / 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rxd,
   input  logic [HALF_W-1:0]   baud_hi,
   input  logic [HALF_W-1:0]   baud_lo,
   input  logic [LEN_W-1:0]    word_len,
   input  logic                parity_en,
   input  logic                parity_odd,
   input  logic                two_stop,
   input  logic [1:0]          mp_mode,
   input  logic                sleep,
   input  logic                rx_irq_en,
   input  logic                rd,
   output logic [MAX_BITS-1:0] rx_data,
   output logic                rx_addr,
   output logic                rx_ready,
   output logic                parity_err,
   output logic                frame_err,
   output logic                overrun_err,
   output logic                break_det,
   output logic                rx_error,
   output logic                rx_irq
);
   if (MAX_BITS < 2 || MAX_BITS != (1 << LEN_W)) begin : g_bad_bits
      $error("mpuart_rx: MAX_BITS must be a power of two, at least 2");
   end
   if (OVS < 4 || OVS != (1 << $clog2(OVS))) begin : g_bad_ovs
      $error("mpuart_rx: OVS must be a power of two, at least 4");
   end
   if (DIV_W % 2 != 0) begin : g_bad_div
      $error("mpuart_rx: DIV_W must be even");
   end

   logic                rxd_s, tick, done, brk_pulse;
   logic [MAX_BITS-1:0] word;
   rx_tag_t             tag;

   mpuart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s));

   mpuart_rx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .div({baud_hi, baud_lo}), .tick(tick));

   mpuart_rx_frame #(.MAX_BITS(MAX_BITS), .OVS(OVS), .IDLE_BITS(IDLE_BITS)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd_s), .word_len(word_len),
      .parity_en(parity_en), .parity_odd(parity_odd), .two_stop(two_stop),
      .mp_mode(mp_mode), .done(done), .data(word), .tag(tag), .brk_pulse(brk_pulse));

   mpuart_rx_hold #(.MAX_BITS(MAX_BITS)) u_hold (
      .clk(clk), .rst_n(rst_n), .done(done), .data_in(word), .tag(tag),
      .brk_pulse(brk_pulse), .mp_mode(mp_mode), .sleep(sleep), .rd(rd),
      .data(rx_data), .is_addr(rx_addr), .ready(rx_ready), .pe(parity_err),
      .fe(frame_err), .oe(overrun_err), .brk(break_det));

   assign rx_error = parity_err | frame_err | overrun_err | break_det;
   assign rx_irq   = break_det | (rx_irq_en & (rx_ready | rx_error));

   // R9: a break always reaches the interrupt output
   p_break_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      break_det |-> rx_irq);
   // R7: break is raised by the line low-run, never by a read
   p_break_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(break_det) |-> $past(brk_pulse));
endmodule

// File: tb/mpuart_rx_bench.sv
module mpuart_rx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic [7:0] baud_hi = 8'd0, baud_lo = 8'd1;
   logic [2:0] word_len = 3'd7;
   logic       parity_en = 1'b0, parity_odd = 1'b0, two_stop = 1'b0;
   logic [1:0] mp_mode = 2'd0;
   logic       sleep = 1'b0, rx_irq_en = 1'b0, rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_addr, rx_ready, parity_err, frame_err, overrun_err;
   logic       break_det, rx_error, rx_irq;

   int total = 0, fails = 0;
   int bit_clk = 32;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   mpuart_rx u_mpuart_rx (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_hi(baud_hi), .baud_lo(baud_lo),
      .word_len(word_len), .parity_en(parity_en), .parity_odd(parity_odd),
      .two_stop(two_stop), .mp_mode(mp_mode), .sleep(sleep), .rx_irq_en(rx_irq_en),
      .rd(rd), .rx_data(rx_data), .rx_addr(rx_addr), .rx_ready(rx_ready),
      .parity_err(parity_err), .frame_err(frame_err), .overrun_err(overrun_err),
      .break_det(break_det), .rx_error(rx_error), .rx_irq(rx_irq));

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [7:0] masked(input logic [7:0] d, input logic [2:0] wl);
      return d & 8'((9'h1 << (int'(wl) + 1)) - 9'h1);
   endfunction

   task automatic drive_bit(input logic b);
      rxd = b;
      repeat (bit_clk) @(negedge clk);
   endtask

   task automatic idle_bits(input int n);
      rxd = 1'b1;
      repeat (n * bit_clk) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input logic abit,
                       input logic flip_par, input logic bad_stop);
      logic [7:0] md;
      logic p;
      md = masked(d, word_len);
      drive_bit(1'b0);
      for (int i = 0; i <= int'(word_len); i++) drive_bit(md[i]);
      if (mp_mode == 2'd2) drive_bit(abit);
      p = (^md) ^ ((mp_mode == 2'd2) ? abit : 1'b0) ^ parity_odd ^ flip_par;
      if (parity_en) drive_bit(p);
      drive_bit(!bad_stop);
      if (two_stop) drive_bit(1'b1);
      idle_bits(2);
   endtask

   task automatic do_read;
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R5 reset ready", rx_ready, 0);
      chk("R8 reset error", rx_error, 0);
      chk("R9 reset irq", rx_irq, 0);
      idle_bits(2);

      // R1: 8-bit word
      send(8'hA5, 0, 0, 0);
      chk("R1 8-bit data", rx_data, 8'hA5);
      chk("R5 ready after word", rx_ready, 1);
      chk("R8 clean word", rx_error, 0);
      do_read();
      chk("R5 rd clears ready", rx_ready, 0);

      // R1: short words right-justified
      word_len = 3'd4;
      send(8'hFF, 0, 0, 0);
      chk("R1 5-bit data", rx_data, 8'h1F);
      do_read();
      word_len = 3'd0;
      send(8'h01, 0, 0, 0);
      chk("R1 1-bit data", rx_data, 8'h01);
      do_read();
      word_len = 3'd7;

      // R2: false start rejected
      rxd = 1'b0;
      repeat (4) @(negedge clk);
      idle_bits(3);
      chk("R2 false start ignored", rx_ready, 0);
      send(8'h3C, 0, 0, 0);
      chk("R2 word after glitch", rx_data, 8'h3C);
      do_read();

      // R2: slower divisor
      baud_lo = 8'd3;
      bit_clk = 64;
      send(8'h96, 0, 0, 0);
      chk("R2 divisor 3 data", rx_data, 8'h96);
      do_read();
      baud_lo = 8'd1;
      bit_clk = 32;
      idle_bits(1);

      // R3: parity
      parity_en = 1'b1;
      send(8'h5A, 0, 0, 0);
      chk("R3 even parity ok", parity_err, 0);
      do_read();
      send(8'h5B, 0, 1, 0);
      chk("R3 even parity bad", parity_err, 1);
      chk("R8 error on parity", rx_error, 1);
      do_read();
      chk("R8 rd clears error", rx_error, 0);
      parity_odd = 1'b1;
      send(8'h77, 0, 0, 0);
      chk("R3 odd parity ok", parity_err, 0);
      chk("R3 odd parity data", rx_data, 8'h77);
      do_read();
      parity_en = 1'b0;
      parity_odd = 1'b0;

      // R4: stop bits
      send(8'hC3, 0, 0, 1);
      chk("R4 missing stop", frame_err, 1);
      do_read();
      two_stop = 1'b1;
      send(8'h81, 0, 0, 0);
      chk("R4 two stop ok", frame_err, 0);
      chk("R4 two stop data", rx_data, 8'h81);
      do_read();
      two_stop = 1'b0;

      // R6: overrun and R9 gating
      send(8'h11, 0, 0, 0);
      chk("R9 irq gated off", rx_irq, 0);
      rx_irq_en = 1'b1;
      @(negedge clk);
      chk("R9 irq enabled", rx_irq, 1);
      rx_irq_en = 1'b0;
      send(8'h22, 0, 0, 0);
      chk("R6 overrun set", overrun_err, 1);
      chk("R6 newest word kept", rx_data, 8'h22);
      chk("R8 error on overrun", rx_error, 1);
      do_read();
      chk("R6 rd clears overrun", overrun_err, 0);

      // R7: break
      rxd = 1'b0;
      repeat (12 * bit_clk) @(negedge clk);
      chk("R7 break detected", break_det, 1);
      chk("R9 break irq without enable", rx_irq, 1);
      chk("R4 break frames error", frame_err, 1);
      idle_bits(2);
      chk("R7 break sticky", break_det, 1);
      do_read();
      chk("R7 rd clears break", break_det, 0);
      send(8'h6E, 0, 0, 0);
      chk("R4 recovers after break", rx_data, 8'h6E);
      do_read();

      // R10 / R12: address marker mode
      mp_mode = 2'd2;
      sleep = 1'b1;
      parity_en = 1'b1;
      send(8'h33, 0, 0, 0);
      chk("R12 data word dropped while asleep", rx_ready, 0);
      send(8'h34, 0, 1, 0);
      chk("R12 dropped word sets no parity", rx_error, 0);
      send(8'h42, 1, 0, 0);
      chk("R10 address accepted", rx_ready, 1);
      chk("R10 address flag", rx_addr, 1);
      chk("R10 address data", rx_data, 8'h42);
      chk("R3 parity covers marker", parity_err, 0);
      do_read();
      sleep = 1'b0;
      send(8'h43, 0, 0, 0);
      chk("R10 data word awake", rx_addr, 0);
      chk("R10 data word ready", rx_ready, 1);
      do_read();
      parity_en = 1'b0;

      // R11 / R12: idle-gap mode
      mp_mode = 2'd1;
      sleep = 1'b1;
      idle_bits(12);
      send(8'h5D, 0, 0, 0);
      chk("R11 first after gap is address", rx_addr, 1);
      chk("R11 address ready", rx_ready, 1);
      do_read();
      send(8'h5E, 0, 0, 0);
      chk("R12 short gap word dropped", rx_ready, 0);
      sleep = 1'b0;
      send(8'h5F, 0, 0, 0);
      chk("R11 short gap not address", rx_addr, 0);
      chk("R11 word data", rx_data, 8'h5F);
      do_read();

      // R12: sleep ignored without a wake-up mode
      mp_mode = 2'd0;
      sleep = 1'b1;
      send(8'h9C, 0, 0, 0);
      chk("R12 sleep ignored in mode 0", rx_ready, 1);
      do_read();
      sleep = 1'b0;

      // random frames
      for (int k = 0; k < 30; k++) begin
         logic [7:0] d;
         logic ab, fl;
         d = 8'($urandom);
         word_len = 3'($urandom);
         parity_en = 1'($urandom);
         parity_odd = 1'($urandom);
         two_stop = 1'($urandom);
         mp_mode = ($urandom % 2 == 0) ? 2'd0 : 2'd2;
         ab = 1'($urandom);
         fl = parity_en && ($urandom % 4 == 0);
         send(d, ab, fl, 0);
         chk("R1 random data", rx_data, masked(d, word_len));
         chk("R3 random parity", parity_err, fl);
         chk("R4 random stop", frame_err, 0);
         chk("R10 random marker", rx_addr, (mp_mode == 2'd2) ? ab : 1'b0);
         do_read();
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule